// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

A 32-bit watchdog peripheral on a plain register bus: an address, a write strobe with write data, and combinational read data. Once armed, the counter counts upward, either on every clock or on ticks from a power-of-two prescaler. When it steps past all-ones it reloads from the load register, records an overflow event and drives a one-cycle reset pulse to the rest of the system. Software keeps the system alive by writing the trigger register with a value that differs from the one it holds. That write reloads the counter before it can wrap.

Six registers are write-protected by a commit delay. These are control, counter, load, trigger, arm/disarm and delay. A write to one of them is first staged and flagged in a pending register. It takes effect only after a fixed hold time, and the flag then drops. Arming and disarming each need a pair of key words written in order. An event register, an enable mask and a masked view feed a level interrupt. A self-clearing soft-reset bit returns the whole block to its reset state.

Top module: `wdg_regtimer`

## Requirements
- R1: After reset the counter, all committed registers, the pending register, the event register and the enables read 0. The block is disarmed, `irq` and `wdt_rst` are low, and the status register (0x14) reads 1.
- R2: A write to control (0x24), counter (0x28), load (0x2C), trigger (0x30), arm (0x48) or delay (0x44) sets its bit in the pending register (0x34). The bits are: control 0, counter 1, load 2, trigger 3, arm 4, delay 5. The bit stays set for HOLD_CYCLES clock edges after the write is captured. Reads of the target register return its old value until the bit clears.
- R3: Committing 0xBBBB and then 0x4444 to the arm register starts the counter. With the prescaler off, the counter then advances by one on every clock.
- R4: Committing 0xAAAA and then 0x5555 to the arm register stops the counter, which then holds its value.
- R5: If a first key word is followed by any value other than its matching second word, the sequence returns to idle and the armed state is unchanged.
- R6: Control bit 5 enables the prescaler and control bits 4:2 hold a ratio p. The counter then advances once every 2^p clocks.
- R7: A committed trigger value that differs from the stored trigger value reloads the counter from the load register. Rewriting the same value leaves the counter untouched.
- R8: A tick at count 0xFFFFFFFF reloads the counter from the load register. It also sets event bit 0 and raises `wdt_rst` for exactly one clock.
- R9: A tick that takes the counter onto the delay register value sets event bit 1.
- R10: Writing 1s to 0x5C sets enable bits and writing 1s to 0x60 clears them; both addresses read the enables. 0x58 reads events AND enables, and `irq` is the OR of those bits.
- R11: Writing a 1 to an event bit at 0x54 or 0x58 clears that bit.
- R12: Writing 1 to bit 1 of the sysconfig register (0x10) holds the block in reset for SRST_CYCLES clocks. During that time the bit reads 1 and status bit 0 reads 0. Afterwards every register is back at its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: any enabled event pending |
| wdt_rst | output | 1 | One-cycle pulse on counter overflow |

## Verification
The bench builds the block with HOLD_CYCLES = 3 and SRST_CYCLES = 4 instead of the defaults of 4 and 8. With these values the pending window can be sampled both while a write is staged and after it has committed. The soft-reset hold also stays short enough to read the busy flag and then see the cleared registers a few cycles later. The 32-bit counter is preloaded a few counts below all-ones, so overflow, reload and the delay match come within reach in a handful of clocks. Prescaler ratios 1 and 2 are measured over windows that are whole multiples of their period, so the expected increment does not depend on the prescaler phase.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int OFFS_W = 8;

    // byte offsets decoded by the register interface
    localparam logic [OFFS_W-1:0] A_SYSCFG = 8'h10;
    localparam logic [OFFS_W-1:0] A_STAT   = 8'h14;
    localparam logic [OFFS_W-1:0] A_CTRL   = 8'h24;
    localparam logic [OFFS_W-1:0] A_COUNT  = 8'h28;
    localparam logic [OFFS_W-1:0] A_LOAD   = 8'h2C;
    localparam logic [OFFS_W-1:0] A_TRIG   = 8'h30;
    localparam logic [OFFS_W-1:0] A_PEND   = 8'h34;
    localparam logic [OFFS_W-1:0] A_DELAY  = 8'h44;
    localparam logic [OFFS_W-1:0] A_ARM    = 8'h48;
    localparam logic [OFFS_W-1:0] A_RAW    = 8'h54;
    localparam logic [OFFS_W-1:0] A_MSK    = 8'h58;
    localparam logic [OFFS_W-1:0] A_ENSET  = 8'h5C;
    localparam logic [OFFS_W-1:0] A_ENCLR  = 8'h60;

    // staged registers, index = bit position in the pending register
    localparam int NSTAGE   = 6;
    localparam int ST_CTRL  = 0;
    localparam int ST_COUNT = 1;
    localparam int ST_LOAD  = 2;
    localparam int ST_TRIG  = 3;
    localparam int ST_ARM   = 4;
    localparam int ST_DELAY = 5;

    // event bits
    localparam int NEVT   = 2;
    localparam int EV_OVF = 0;
    localparam int EV_DLY = 1;

    // arm/disarm key words
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_GO1   = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_GO2   = 16'h4444;
    localparam logic [KEY_W-1:0] KEY_HALT1 = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_HALT2 = 16'h5555;

    localparam int RATIO_W = 3;

    typedef enum logic [1:0] {
        ARM_IDLE,
        ARM_GO_HALF,
        ARM_HALT_HALF
    } arm_state_e;

    typedef struct packed {
        logic               pre_en;
        logic [RATIO_W-1:0] ratio;
    } psc_cfg_t;

    function automatic logic [OFFS_W-1:0] stage_addr(input int idx);
        case (idx)
            ST_CTRL:  return A_CTRL;
            ST_COUNT: return A_COUNT;
            ST_LOAD:  return A_LOAD;
            ST_TRIG:  return A_TRIG;
            ST_ARM:   return A_ARM;
            default:  return A_DELAY;
        endcase
    endfunction

endpackage

// File: rtl/wdg_stage.sv
module wdg_stage #(
    parameter int DATA_W = 32,
    parameter int HOLD   = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic              pend,
    output logic              commit,
    output logic [DATA_W-1:0] dout
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            dout   <= '0;
        end else if (wr) begin
            left_q <= HW'(HOLD);
            dout   <= din;
        end else if (left_q != '0) begin
            left_q <= left_q - HW'(1);
        end
    end

    assign pend   = (left_q != '0);
    assign commit = (left_q == HW'(1));

    // R2: a captured write is always flagged pending
    p_wr_pends_r2: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend);
    // R2: the pending flag drops right after the commit cycle
    p_commit_ends_r2: assert property (@(posedge clk) disable iff (rst)
        commit && !wr |=> !pend);
    // R2: the staged value holds while waiting
    p_staged_stable_r2: assert property (@(posedge clk) disable iff (rst)
        pend && !wr |=> $stable(dout));
endmodule

// File: rtl/wdg_arm_seq.sv
module wdg_arm_seq import wdg_pkg::*; #(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] value,
    output logic              running
);
    arm_state_e       st_q;
    logic             hi_zero;
    logic [KEY_W-1:0] key;

    assign hi_zero = (value[DATA_W-1:KEY_W] == '0);
    assign key     = value[KEY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ARM_IDLE;
            running <= 1'b0;
        end else if (valid) begin
            case (st_q)
                ARM_IDLE: begin
                    if (hi_zero && key == KEY_GO1)        st_q <= ARM_GO_HALF;
                    else if (hi_zero && key == KEY_HALT1) st_q <= ARM_HALT_HALF;
                    else                                  st_q <= ARM_IDLE;
                end
                ARM_GO_HALF: begin
                    st_q <= ARM_IDLE;
                    if (hi_zero && key == KEY_GO2) running <= 1'b1;
                end
                ARM_HALT_HALF: begin
                    st_q <= ARM_IDLE;
                    if (hi_zero && key == KEY_HALT2) running <= 1'b0;
                end
                default: st_q <= ARM_IDLE;
            endcase
        end
    end

    // R3 / R4: the armed state moves only on a committed write
    p_run_needs_commit_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(running) |-> $past(valid));
    // R5: a first key word alone never changes the armed state
    p_first_word_inert_r5: assert property (@(posedge clk) disable iff (rst)
        valid && st_q == ARM_IDLE |=> $stable(running));
endmodule

// File: rtl/wdg_count.sv
module wdg_count import wdg_pkg::*; #(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  psc_cfg_t          cfg,
    input  logic              ld_cnt,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              reload,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] dly_val,
    output logic [DATA_W-1:0] count,
    output logic              ovf,
    output logic              dly_hit
);
    localparam int DIV_W = 1 << RATIO_W;

    logic [DIV_W-1:0]  psc_q, psc_lim;
    logic              tick, free_step;
    logic [DATA_W-1:0] next_cnt;

    assign psc_lim = (DIV_W'(1) << cfg.ratio) - DIV_W'(1);
    assign tick    = run && (!cfg.pre_en || psc_q >= psc_lim);

    always_ff @(posedge clk) begin
        if (rst || !run || !cfg.pre_en) psc_q <= '0;
        else if (psc_q >= psc_lim)      psc_q <= '0;
        else                            psc_q <= psc_q + DIV_W'(1);
    end

    assign next_cnt  = count + DATA_W'(1);
    assign free_step = tick && !ld_cnt && !reload;
    assign ovf       = free_step && (count == '1);
    assign dly_hit   = free_step && (count != '1) && (next_cnt == dly_val);

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (ld_cnt) count <= cnt_val;
        else if (reload) count <= load_val;
        else if (ovf)    count <= load_val;
        else if (tick)   count <= next_cnt;
    end

    // R8: wrapping past all-ones lands on the load value
    p_ovf_reload_r8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> count == $past(load_val));
    // R4: a disarmed counter with no commit holds
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !run && !ld_cnt && !reload |=> $stable(count));
    // R6: a plain tick advances by exactly one
    p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
        free_step && count != '1 |=> count == $past(count) + DATA_W'(1));
endmodule

// File: rtl/wdg_regtimer.sv
module wdg_regtimer import wdg_pkg::*; #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int HOLD_CYCLES = 4,
    parameter int SRST_CYCLES = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdt_rst
);
    localparam int SRST_W = $clog2(SRST_CYCLES + 1);

    // soft reset hold
    logic [SRST_W-1:0] srst_cnt;
    logic              srst_busy, irst;

    always_ff @(posedge clk) begin
        if (rst)                    srst_cnt <= '0;
        else if (srst_cnt != '0)    srst_cnt <= srst_cnt - SRST_W'(1);
        else if (wr_en && addr == ADDR_W'(A_SYSCFG) && wdata[1])
                                    srst_cnt <= SRST_W'(SRST_CYCLES);
    end

    assign srst_busy = (srst_cnt != '0);
    assign irst      = rst | srst_busy;

    // staged registers
    logic [NSTAGE-1:0] st_pend, st_commit;
    logic [DATA_W-1:0] st_data [NSTAGE];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        wdg_stage #(.DATA_W(DATA_W), .HOLD(HOLD_CYCLES)) u_stage (
            .clk    (clk),
            .rst    (irst),
            .wr     (wr_en && addr == ADDR_W'(stage_addr(g))),
            .din    (wdata),
            .pend   (st_pend[g]),
            .commit (st_commit[g]),
            .dout   (st_data[g])
        );
    end

    logic [DATA_W-1:0] ctrl_q, load_q, trig_q, dly_q, arm_q;
    logic              trig_reload;

    assign trig_reload = st_commit[ST_TRIG] && (st_data[ST_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (irst) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
            dly_q  <= '0;
            arm_q  <= '0;
        end else begin
            if (st_commit[ST_CTRL])  ctrl_q <= st_data[ST_CTRL];
            if (st_commit[ST_LOAD])  load_q <= st_data[ST_LOAD];
            if (st_commit[ST_TRIG])  trig_q <= st_data[ST_TRIG];
            if (st_commit[ST_DELAY]) dly_q  <= st_data[ST_DELAY];
            if (st_commit[ST_ARM])   arm_q  <= st_data[ST_ARM];
        end
    end

    logic running;

    wdg_arm_seq #(.DATA_W(DATA_W)) u_arm (
        .clk     (clk),
        .rst     (irst),
        .valid   (st_commit[ST_ARM]),
        .value   (st_data[ST_ARM]),
        .running (running)
    );

    psc_cfg_t          cfg;
    logic [DATA_W-1:0] count_q;
    logic              ovf_evt, dly_evt;

    assign cfg.pre_en = ctrl_q[5];
    assign cfg.ratio  = ctrl_q[4:2];

    wdg_count #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (irst),
        .run      (running),
        .cfg      (cfg),
        .ld_cnt   (st_commit[ST_COUNT]),
        .cnt_val  (st_data[ST_COUNT]),
        .reload   (trig_reload),
        .load_val (load_q),
        .dly_val  (dly_q),
        .count    (count_q),
        .ovf      (ovf_evt),
        .dly_hit  (dly_evt)
    );

    // events, enables, reset pulse
    logic [NEVT-1:0] raw_q, en_q, hit, clr_mask;

    always_comb begin
        hit         = '0;
        hit[EV_OVF] = ovf_evt;
        hit[EV_DLY] = dly_evt;
    end

    assign clr_mask = (wr_en && (addr == ADDR_W'(A_RAW) || addr == ADDR_W'(A_MSK)))
                    ? wdata[NEVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (irst) begin
            raw_q   <= '0;
            en_q    <= '0;
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= ovf_evt;
            raw_q   <= (raw_q & ~clr_mask) | hit;
            if (wr_en && addr == ADDR_W'(A_ENSET)) en_q <= en_q | wdata[NEVT-1:0];
            else if (wr_en && addr == ADDR_W'(A_ENCLR)) en_q <= en_q & ~wdata[NEVT-1:0];
        end
    end

    assign irq = |(raw_q & en_q);

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_SYSCFG): rdata = DATA_W'({srst_busy, 1'b0});
            ADDR_W'(A_STAT):   rdata = DATA_W'(!srst_busy);
            ADDR_W'(A_CTRL):   rdata = ctrl_q;
            ADDR_W'(A_COUNT):  rdata = count_q;
            ADDR_W'(A_LOAD):   rdata = load_q;
            ADDR_W'(A_TRIG):   rdata = trig_q;
            ADDR_W'(A_PEND):   rdata = DATA_W'(st_pend);
            ADDR_W'(A_DELAY):  rdata = dly_q;
            ADDR_W'(A_ARM):    rdata = arm_q;
            ADDR_W'(A_RAW):    rdata = DATA_W'(raw_q);
            ADDR_W'(A_MSK):    rdata = DATA_W'(raw_q & en_q);
            ADDR_W'(A_ENSET),
            ADDR_W'(A_ENCLR):  rdata = DATA_W'(en_q);
            default:           rdata = '0;
        endcase
    end

    // R8: the reset pulse is always accompanied by the overflow event
    p_pulse_has_event_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> raw_q[EV_OVF]);
    // R12: the soft reset clears the counter
    p_srst_clears_r12: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> count_q == '0);
    // R10: no interrupt without an enable
    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_q != '0);
endmodule

// File: tb/wdg_regtimer_test.sv
module wdg_regtimer_test;
    import wdg_pkg::*;

    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int HOLD = 3;
    localparam int SRST = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, wdt_rst;

    always #10 clk = ~clk;

    wdg_regtimer #(.DATA_W(DW), .ADDR_W(AW), .HOLD_CYCLES(HOLD), .SRST_CYCLES(SRST)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .irq(irq), .wdt_rst(wdt_rst)
    );

    typedef enum {K_DATA, K_IRQ} kind_e;
    typedef struct {
        kind_e         kind;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t exp_q[$];
    logic  chk_req = 1'b0;
    int    n_vec = 0, n_bad = 0, rst_hi = 0;

    // monitor: pops one expected item per flagged cycle
    always @(negedge clk) begin : mon
        item_t         it;
        logic [DW-1:0] act;
        if (wdt_rst) rst_hi++;
        if (chk_req && exp_q.size() > 0) begin
            it  = exp_q.pop_front();
            act = (it.kind == K_DATA) ? rdata : DW'(irq);
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic check_now(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk);
        #2;
        wr_en   = w;
        addr    = a;
        wdata   = d;
        chk_req = 1'b0;
    endtask

    task automatic drv_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        slot(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, addr, '0);
    endtask

    task automatic drv_write_sync(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drv_write(a, d);
        idle(HOLD + 1);
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        item_t it;
        slot(1'b0, a, '0);
        it.kind = K_DATA; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        chk_req = 1'b1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        slot(1'b0, addr, '0);
        it.kind = K_IRQ; it.exp = DW'(e); it.tag = tag;
        exp_q.push_back(it);
        chk_req = 1'b1;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
        slot(1'b0, a, '0);
        @(negedge clk);
        v = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin : driver
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        expect_rd(A_COUNT, 32'h0, "R1 counter");
        expect_rd(A_PEND,  32'h0, "R1 pending");
        expect_rd(A_STAT,  32'h1, "R1 status");
        expect_irq(1'b0, "R1 irq");

        // R2 staged writes and pending bits
        drv_write(A_COUNT, 32'd100);
        expect_rd(A_PEND,  32'h2, "R2 counter pending");
        expect_rd(A_COUNT, 32'h0, "R2 old counter value");
        idle(3);
        expect_rd(A_COUNT, 32'd100, "R2 counter committed");
        expect_rd(A_PEND,  32'h0, "R2 pending cleared");
        drv_write(A_LOAD, 32'h500);
        expect_rd(A_PEND, 32'h4, "R2 load pending");
        idle(3);
        expect_rd(A_LOAD, 32'h500, "R2 load committed");
        drv_write(A_DELAY, 32'hFFFF_FFFE);
        expect_rd(A_PEND, 32'h20, "R2 delay pending");
        idle(3);

        // R7 trigger refresh
        drv_write_sync(A_TRIG, 32'h1);
        expect_rd(A_COUNT, 32'h500, "R7 differing trigger reloads");
        drv_write_sync(A_COUNT, 32'd7);
        drv_write(A_TRIG, 32'h1);
        expect_rd(A_PEND, 32'h8, "R2 trigger pending");
        idle(3);
        expect_rd(A_COUNT, 32'd7, "R7 same trigger ignored");

        // R5 broken start sequence
        drv_write(A_ARM, 32'hBBBB);
        expect_rd(A_PEND, 32'h10, "R2 arm pending");
        idle(3);
        drv_write_sync(A_ARM, 32'h1234);
        drv_write_sync(A_ARM, 32'h4444);
        idle(5);
        expect_rd(A_COUNT, 32'd7, "R5 broken sequence stays stopped");

        // R3 start
        drv_write_sync(A_ARM, 32'hBBBB);
        drv_write_sync(A_ARM, 32'h4444);
        peek(A_COUNT, v);
        idle(9);
        expect_rd(A_COUNT, v + 32'd10, "R3 counts every clock");

        // R6 prescaler, ratio 2 then ratio 1
        drv_write_sync(A_CTRL, 32'h28);
        expect_rd(A_CTRL, 32'h28, "R6 control readback");
        peek(A_COUNT, v);
        idle(15);
        expect_rd(A_COUNT, v + 32'd4, "R6 ratio 2 over 16 clocks");
        drv_write_sync(A_CTRL, 32'h24);
        peek(A_COUNT, v);
        idle(7);
        expect_rd(A_COUNT, v + 32'd4, "R6 ratio 1 over 8 clocks");
        drv_write_sync(A_CTRL, 32'h0);

        // R4 stop
        drv_write_sync(A_ARM, 32'hAAAA);
        drv_write_sync(A_ARM, 32'h5555);
        peek(A_COUNT, v);
        idle(5);
        expect_rd(A_COUNT, v, "R4 stopped counter holds");

        // R8 / R9 / R10 overflow run
        drv_write(A_ENSET, 32'h2);
        expect_rd(A_ENSET, 32'h2, "R10 enable set");
        drv_write_sync(A_LOAD, 32'h10);
        drv_write_sync(A_COUNT, 32'hFFFF_FFFB);
        expect_rd(A_RAW, 32'h0, "R9 no event before run");
        check_now("R1 no reset pulse yet", DW'(rst_hi), 32'd0);
        drv_write_sync(A_ARM, 32'hBBBB);
        drv_write_sync(A_ARM, 32'h4444);
        idle(3);
        drv_write_sync(A_ARM, 32'hAAAA);
        drv_write_sync(A_ARM, 32'h5555);
        check_now("R8 reset pulse length", DW'(rst_hi), 32'd1);
        expect_rd(A_RAW, 32'h3, "R8 R9 events raised");
        expect_rd(A_MSK, 32'h2, "R10 masked status");
        expect_irq(1'b1, "R10 irq from delay event");
        peek(A_COUNT, v);
        check_now("R8 reloaded from load", DW'(v >= 32'h10 && v < 32'h40), 32'd1);

        // R10 enable clear / set
        drv_write(A_ENCLR, 32'h2);
        expect_irq(1'b0, "R10 irq masked");
        expect_rd(A_ENCLR, 32'h0, "R10 enables cleared");
        drv_write(A_ENSET, 32'h1);
        expect_irq(1'b1, "R10 irq from overflow");
        expect_rd(A_MSK, 32'h1, "R10 masked overflow");

        // R11 write-one-to-clear
        drv_write(A_RAW, 32'h1);
        expect_rd(A_RAW, 32'h2, "R11 overflow cleared");
        expect_irq(1'b0, "R11 irq dropped");
        drv_write(A_MSK, 32'h2);
        expect_rd(A_RAW, 32'h0, "R11 delay cleared");

        // R12 soft reset
        drv_write_sync(A_LOAD, 32'h77);
        drv_write(A_SYSCFG, 32'h2);
        expect_rd(A_SYSCFG, 32'h2, "R12 busy bit");
        expect_rd(A_STAT, 32'h0, "R12 status during reset");
        idle(4);
        expect_rd(A_SYSCFG, 32'h0, "R12 busy self-clears");
        expect_rd(A_LOAD, 32'h0, "R12 load cleared");
        expect_rd(A_COUNT, 32'h0, "R12 counter cleared");
        idle(2);

        summary();
        $finish;
    end
endmodule